// File: doc/BRIEF.md
# Byte-Serial Page Parity Code Generator

This block computes a single-error-correcting, double-error-detecting parity code over a block of data bytes fed one per cycle. The block is 256 bytes by default, or 512 bytes when a parameter selects the wide mode. A start strobe opens a block. Each byte accepted with its valid flag set adds to two sets of running parities:

- **Column parities.** Six bits, each covering fixed bit columns of every byte.
- **Row parities.** Pairs of bits selected by the byte's position in the block. For each bit of the running byte index, the parity of the whole byte goes into one member of a complementary pair.

When the last byte is accepted, the parities are packed into three code bytes. The code bytes are registered, a one-cycle done pulse marks them, and they stay unchanged until the next block completes.

The sequencer has three named states:

- **IDLE:** entered after reset. A start moves it to FILL.
- **FILL:** counts accepted bytes. A start while in FILL restarts the block and stays in FILL. Accepting the final byte moves it to HOLD.
- **HOLD:** the code is held. A start moves it to FILL.

Bytes presented in IDLE or HOLD, or without valid, are ignored.

Top module: `hamming_page_parity`

## Requirements
- R1: After reset, done_o is 0 and all three code bytes are 0x00. No byte is accepted until a start strobe.
- R2: Code byte 2 bit (k+2) holds column parity k, for k = 0 to 5. The parities are XORs over every accepted byte:
  - k=0 covers bits {0,2,4,6}.
  - k=1 covers bits {1,3,5,7}.
  - k=2 covers bits {0,1,4,5}.
  - k=3 covers bits {2,3,6,7}.
  - k=4 covers bits {0..3}.
  - k=5 covers bits {4..7}.
- R3: For each index bit j of the byte's position in the block (first byte = 0), the XOR of all 8 bits of the byte goes into row parity 2j+1 when index bit j is 1, and into row parity 2j when it is 0. Row parity i sits at code byte 0 bit i for i = 0 to 7, and at code byte 1 bit (i-8) for i = 8 to 15.
- R4: In 256-byte mode, code byte 2 bits 1 and 0 are always 1 in a completed code. A block of all-zero or all-one bytes therefore gives the code bytes 0x00, 0x00, 0x03.
- R5: done_o is 1 for exactly one cycle, starting at the clock edge that accepts the final byte of the block. The code bytes are updated at that same edge.
- R6: A byte presented with valid_i low, or while no block is open (IDLE or HOLD), changes neither the code nor the running parities.
- R7: start_i clears all running parities and the byte index, from any state. A byte presented in the same cycle as start_i is discarded.
- R8: The code bytes change only at the edge that raises done_o. They hold their value through idle cycles, ignored bytes and a newly started block, until that block completes.
- R9: Changing one data bit at byte position p, bit b, flips exactly 11 code bits in 256-byte mode:
  - Code byte 1 bits 7,5,3,1 and code byte 0 bits 7,5,3,1, read in that order, spell p.
  - Code byte 2 bits 7,5,3 spell b.
- R10: With WIDE_MODE=1 the block is 512 bytes. Index bit 8 drives row parities 16 and 17, which sit at code byte 2 bits 0 and 1 in place of the filler ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Opens a new block and clears all running parities |
| valid_i | input | 1 | byte_i carries a data byte this cycle |
| byte_i | input | 8 | Data byte |
| code0_o | output | 8 | Code byte 0: row parities 7..0 |
| code1_o | output | 8 | Code byte 1: row parities 15..8 |
| code2_o | output | 8 | Code byte 2: column parities 5..0 in bits 7..2, then fillers or row parities 17..16 |
| done_o | output | 1 | One-cycle pulse marking a freshly completed code |

## Verification
A byte driven before a rising edge is absorbed at that edge. The final byte's edge both loads the code registers and raises done_o, so the finished code and the pulse are due one register stage after the last byte is presented. They are not due any later than that. The bench drives inputs on falling edges and checks the code and done_o on the falling edge that follows the accepting edge. It checks that done_o has dropped and the code is unchanged one falling edge later. For the ignored-byte and hold cases, the code bytes are checked again on the falling edges after the stray bytes.

// File: rtl/hpg_pkg.sv
package hpg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_HOLD = 2'd2
    } hpg_state_e;

    localparam logic [7:0] COL_MASK0 = 8'h55;
    localparam logic [7:0] COL_MASK1 = 8'hAA;
    localparam logic [7:0] COL_MASK2 = 8'h33;
    localparam logic [7:0] COL_MASK3 = 8'hCC;
    localparam logic [7:0] COL_MASK4 = 8'h0F;
    localparam logic [7:0] COL_MASK5 = 8'hF0;

    function automatic logic [5:0] col_terms(input logic [7:0] b);
        logic [5:0] t;
        t[0] = ^(b & COL_MASK0);
        t[1] = ^(b & COL_MASK1);
        t[2] = ^(b & COL_MASK2);
        t[3] = ^(b & COL_MASK3);
        t[4] = ^(b & COL_MASK4);
        t[5] = ^(b & COL_MASK5);
        return t;
    endfunction

endpackage

// File: rtl/hpg_col_acc.sv
module hpg_col_acc
    import hpg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       en,
    input  logic [7:0] byte_i,
    output logic       row_par_o,
    output logic [5:0] cp_nxt_o
);
    logic [5:0] cp_q;
    logic [5:0] terms;

    assign terms     = col_terms(byte_i);
    assign row_par_o = ^byte_i;

    always_comb begin
        if (clr) begin
            cp_nxt_o = '0;
        end else if (en) begin
            cp_nxt_o = cp_q ^ terms;
        end else begin
            cp_nxt_o = cp_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cp_q <= '0;
        end else begin
            cp_q <= cp_nxt_o;
        end
    end

    // R6
    col_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(cp_q));

    // R7
    col_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cp_q == '0));

endmodule

// File: rtl/hpg_row_acc.sv
module hpg_row_acc #(
    parameter int IDX_W = 8,
    localparam int RP_W = 2 * IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic             par_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [RP_W-1:0]  rp_nxt_o
);
    logic [RP_W-1:0] rp_q;

    for (genvar k = 0; k < IDX_W; k++) begin : g_pair
        logic hit;
        assign hit = en & par_i;
        assign rp_nxt_o[2*k+1] = clr ? 1'b0 : (rp_q[2*k+1] ^ (hit & idx_i[k]));
        assign rp_nxt_o[2*k]   = clr ? 1'b0 : (rp_q[2*k]   ^ (hit & ~idx_i[k]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rp_q <= '0;
        end else begin
            rp_q <= rp_nxt_o;
        end
    end

    // R6
    row_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(rp_q));

    // R3: each accepted byte touches at most one member of each pair
    row_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !clr) |=> ($countones(rp_q ^ $past(rp_q)) == (IDX_W * int'($past(par_i)))));

endmodule

// File: rtl/hpg_seq.sv
module hpg_seq
    import hpg_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             valid_i,
    output logic             clr_o,
    output logic             acc_en_o,
    output logic             fin_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             done_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

    hpg_state_e state_q, state_d;

    assign clr_o    = start_i;
    assign acc_en_o = (state_q == ST_FILL) && valid_i && !start_i;
    assign fin_o    = acc_en_o && (idx_o == LAST_IDX);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_FILL;
            ST_FILL: begin
                if (start_i)    state_d = ST_FILL;
                else if (fin_o) state_d = ST_HOLD;
            end
            ST_HOLD: if (start_i) state_d = ST_FILL;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_o  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= fin_o;
            if (start_i)       idx_o <= '0;
            else if (acc_en_o) idx_o <= idx_o + 1'b1;
        end
    end

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R5
    done_cause_chk: assert property (@(posedge clk) disable iff (rst)
        fin_o |=> (done_o && state_q == ST_HOLD));

    // R7
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (idx_o == '0 && state_q == ST_FILL));

    // R6
    idle_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_FILL) |-> !acc_en_o);

endmodule

// File: rtl/hamming_page_parity.sv
module hamming_page_parity
    import hpg_pkg::*;
#(
    parameter bit WIDE_MODE = 1'b0,
    localparam int IDX_W = WIDE_MODE ? 9 : 8,
    localparam int RP_W  = 2 * IDX_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       valid_i,
    input  logic [7:0] byte_i,
    output logic [7:0] code0_o,
    output logic [7:0] code1_o,
    output logic [7:0] code2_o,
    output logic       done_o
);
    logic             clr, acc_en, fin, row_par;
    logic [IDX_W-1:0] idx;
    logic [5:0]       cp_nxt;
    logic [RP_W-1:0]  rp_nxt;
    logic [1:0]       low_pair;

    hpg_seq #(.IDX_W(IDX_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .valid_i  (valid_i),
        .clr_o    (clr),
        .acc_en_o (acc_en),
        .fin_o    (fin),
        .idx_o    (idx),
        .done_o   (done_o)
    );

    hpg_col_acc u_col (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .en        (acc_en),
        .byte_i    (byte_i),
        .row_par_o (row_par),
        .cp_nxt_o  (cp_nxt)
    );

    hpg_row_acc #(.IDX_W(IDX_W)) u_row (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .en       (acc_en),
        .par_i    (row_par),
        .idx_i    (idx),
        .rp_nxt_o (rp_nxt)
    );

    if (WIDE_MODE) begin : g_wide
        assign low_pair = rp_nxt[17:16];
    end else begin : g_narrow
        assign low_pair = 2'b11;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code0_o <= '0;
            code1_o <= '0;
            code2_o <= '0;
        end else if (fin) begin
            code0_o <= rp_nxt[7:0];
            code1_o <= rp_nxt[15:8];
            code2_o <= {cp_nxt, low_pair};
        end
    end

    // R8
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable({code0_o, code1_o, code2_o}) |-> done_o);

    if (!WIDE_MODE) begin : g_fill_chk
        // R4
        filler_ones_chk: assert property (@(posedge clk) disable iff (rst)
            done_o |-> (code2_o[1:0] == 2'b11));
    end

endmodule

// File: tb/hamming_page_parity_bench.sv
module hamming_page_parity_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic       st_n = 0, vl_n = 0, st_w = 0, vl_w = 0;
    logic [7:0] by_n = 0, by_w = 0;
    logic [7:0] c0_n, c1_n, c2_n, c0_w, c1_w, c2_w;
    logic       dn_n, dn_w;

    hamming_page_parity u_hamming_page_parity (
        .clk(clk), .rst(rst), .start_i(st_n), .valid_i(vl_n), .byte_i(by_n),
        .code0_o(c0_n), .code1_o(c1_n), .code2_o(c2_n), .done_o(dn_n));

    hamming_page_parity #(.WIDE_MODE(1'b1)) u_hamming_page_parity_wide (
        .clk(clk), .rst(rst), .start_i(st_w), .valid_i(vl_w), .byte_i(by_w),
        .code0_o(c0_w), .code1_o(c1_w), .code2_o(c2_w), .done_o(dn_w));

    int checks = 0;
    int errors = 0;
    logic [7:0] d [512];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] model(input int n);
        logic [5:0]  cp = '0;
        logic [17:0] rp = '0;
        int iw = (n == 512) ? 9 : 8;
        for (int i = 0; i < n; i++) begin
            logic par = 1'b0;
            for (int j = 0; j < 8; j++) begin
                if (d[i][j]) begin
                    par = ~par;
                    cp[(j % 2)]           = ~cp[(j % 2)];
                    cp[2 + ((j / 2) % 2)] = ~cp[2 + ((j / 2) % 2)];
                    cp[4 + (j / 4)]       = ~cp[4 + (j / 4)];
                end
            end
            for (int k = 0; k < iw; k++)
                if (par) rp[2*k + ((i >> k) & 1)] = ~rp[2*k + ((i >> k) & 1)];
        end
        return {cp, (n == 512) ? rp[17:16] : 2'b11, rp[15:8], rp[7:0]};
    endfunction

    function automatic logic [23:0] dut_code(input bit wide);
        return wide ? {c2_w, c1_w, c0_w} : {c2_n, c1_n, c0_n};
    endfunction

    function automatic logic dut_done(input bit wide);
        return wide ? dn_w : dn_n;
    endfunction

    task automatic drive(input bit wide, input logic s, input logic v, input logic [7:0] b);
        if (wide) begin st_w = s; vl_w = v; by_w = b; end
        else      begin st_n = s; vl_n = v; by_n = b; end
    endtask

    // feeds a whole block, checks code and done timing; returns code seen
    task automatic run_block(input bit wide, input bit gaps, input logic sv, input string tag,
                             output logic [23:0] got);
        int n = wide ? 512 : 256;
        logic [23:0] exp = model(n);
        @(negedge clk) drive(wide, 1, sv, 8'hFF);
        for (int i = 0; i < n; i++) begin
            if (gaps) begin
                while ($urandom % 4 == 0) begin
                    @(negedge clk) drive(wide, 0, 0, 8'($urandom));
                end
            end
            @(negedge clk) drive(wide, 0, 1, d[i]);
            if (i < n - 1) chk(!dut_done(wide), {tag, " R5 early done"}, 32'(dut_done(wide)), 0);
        end
        @(negedge clk) drive(wide, 0, 0, 8'h00);
        got = dut_code(wide);
        chk(dut_done(wide) == 1'b1, {tag, " R5 done"}, 32'(dut_done(wide)), 1);
        chk(got == exp, {tag, " R2 R3 code"}, 32'(got), 32'(exp));
        @(negedge clk);
        chk(dut_done(wide) == 1'b0, {tag, " R5 pulse"}, 32'(dut_done(wide)), 0);
        chk(dut_code(wide) == got, {tag, " R8 hold"}, 32'(dut_code(wide)), 32'(got));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [23:0] got, held;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        chk(dn_n == 0 && {c2_n, c1_n, c0_n} == 0, "R1 reset", {c2_n, c1_n, c0_n}, 0);
        drive(0, 0, 1, 8'h5A);
        @(negedge clk); @(negedge clk);
        chk({c2_n, c1_n, c0_n} == 0 && dn_n == 0, "R1 no block before start", {c2_n, c1_n, c0_n}, 0);

        // R4 zeros and ones
        for (int i = 0; i < 256; i++) d[i] = 8'h00;
        run_block(0, 0, 0, "zeros", got);
        chk(got == 24'h030000, "R4 zeros", got, 24'h030000);
        for (int i = 0; i < 256; i++) d[i] = 8'hFF;
        run_block(0, 0, 0, "ones", got);
        chk(got == 24'h030000, "R4 ones", got, 24'h030000);

        // R9 single-bit sweep over every byte position
        for (int p = 0; p < 256; p++) begin
            logic [23:0] df;
            logic [7:0]  pa;
            logic [2:0]  ba;
            for (int i = 0; i < 256; i++) d[i] = 8'h00;
            d[p] = 8'(1 << (p % 8));
            run_block(0, 0, 0, "sweep", got);
            df = got ^ 24'h030000;
            pa = {df[15], df[13], df[11], df[9], df[7], df[5], df[3], df[1]};
            ba = {df[23], df[21], df[19]};
            chk($countones(df) == 11, "R9 weight", $countones(df), 11);
            chk(pa == 8'(p) && ba == 3'(p % 8), "R9 address", {pa, 5'd0, ba}, {8'(p), 5'd0, 3'(p % 8)});
        end

        // R6 random data with invalid garbage interleaved
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < 256; i++) d[i] = 8'($urandom);
            run_block(0, 1, 0, "R6 gaps", got);
        end

        // R6 R8 valid bytes in HOLD ignored
        held = {c2_n, c1_n, c0_n};
        for (int i = 0; i < 20; i++) begin
            @(negedge clk) drive(0, 0, 1, 8'($urandom));
        end
        @(negedge clk) drive(0, 0, 0, 0);
        @(negedge clk);
        chk({c2_n, c1_n, c0_n} == held && dn_n == 0, "R6 hold ignore", {c2_n, c1_n, c0_n}, held);

        // R7 restart mid-block; R8 code held while new block fills
        @(negedge clk) drive(0, 1, 0, 0);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk) drive(0, 0, 1, 8'($urandom));
        end
        @(negedge clk) drive(0, 0, 0, 0);
        chk({c2_n, c1_n, c0_n} == held, "R8 held during fill", {c2_n, c1_n, c0_n}, held);
        for (int i = 0; i < 256; i++) d[i] = 8'(i * 7 + 3);
        run_block(0, 0, 0, "R7 restart", got);
        // R7 byte with start dropped
        for (int i = 0; i < 256; i++) d[i] = 8'(i ^ 8'hA5);
        run_block(0, 0, 1, "R7 start+valid", got);

        // R10 wide mode
        for (int i = 0; i < 512; i++) d[i] = 8'h00;
        d[300] = 8'h08;
        run_block(1, 0, 0, "R10 wide single", got);
        chk(got[17:16] == 2'b10, "R10 index bit 8", got[17:16], 2'b10);
        for (int r = 0; r < 2; r++) begin
            for (int i = 0; i < 512; i++) d[i] = 8'($urandom);
            run_block(1, 1, 0, "R10 wide random", got);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule